// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block drives the reset lines of a processor and supervises it with a strobe-serviced watchdog. It takes a digital supply-good flag from an external comparator, a raw pushbutton input, a strobe from software, a watchdog-enable flag (low when the strobe source is left undriven), a clock-source select, a period select and a one-cycle timing tick. It produces an active-high and an active-low reset, plus a latched active-low watchdog-status flag.

Reset is held for a programmable number of ticks after every cause goes away: supply failure, a qualified pushbutton press, or a watchdog timeout. Once reset is released, the watchdog counts ticks. Each falling strobe edge restarts the count. The first period after any reset is long. Later periods are short, unless internal-clock mode is selected with the period select high, in which case every period is long. All lengths are parameters counted in ticks.

Top module: `supv_reset_wdog`

## Requirements
- R1: While `rst_n` is low, `reset_o` is 1, `reset_n_o` is 0 and `wdog_stat_n_o` is 1 (given supply good). `reset_n_o` is always the inverse of `reset_o`.
- R2: When `supply_ok` is 0, `reset_o` is 1 and `wdog_stat_n_o` is 0 in the same cycle, with no clock edge needed.
- R3: Reset releases on the clock edge of the N-th tick sampled with every cause absent. N is `RST_EXT_TICKS` when `clk_int`=0 and `RST_INT_TICKS` when `clk_int`=1.
- R4: `button_n` held low (after two-flop synchronization) for `PB_TICKS` ticks asserts reset. A shorter press has no effect. Reset stays asserted while the button is held and releases as in R3 after the button is let go.
- R5: The watchdog does not count while reset is active.
- R6: With `clk_int`=0, the first period after any reset is `WD_EXT_SHORT*WD_LONG_FACTOR` ticks. Later periods, each following a strobe fall, are `WD_EXT_SHORT` ticks.
- R7: A high-to-low edge on the synchronized `strobe` restarts the watchdog count and clears the latched status. A rising edge has no effect. Strobes spaced closer than the period prevent any timeout.
- R8: On timeout, `reset_o` is asserted and `wdog_stat_n_o` goes to 0. The status stays 0 through the reset and afterwards, until a strobe fall or `wd_enable`=0.
- R9: While `wd_enable` is 0, the watchdog never times out and the latched status is cleared.
- R10: With `clk_int`=1 and `long_sel`=1, every period is `WD_INT_LONG` ticks. With `clk_int`=1 and `long_sel`=0, the first period is `WD_INT_LONG` ticks and later ones are `WD_INT_SHORT` ticks.
- R11: A supply failure clears the watchdog count. When supply returns, the next period is the long first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, released synchronously |
| tick | input | 1 | One-cycle timing enable; all lengths are counted in ticks |
| supply_ok | input | 1 | Supply-good flag from the external comparator (1 = good) |
| button_n | input | 1 | Raw pushbutton input, low = pressed |
| strobe | input | 1 | Watchdog service strobe; falling edge services the watchdog |
| wd_enable | input | 1 | 1 = watchdog active; 0 = strobe source undriven, watchdog off |
| clk_int | input | 1 | 0 = external-clock timing set, 1 = internal-clock timing set |
| long_sel | input | 1 | In internal mode, 1 = every period is long |
| reset_o | output | 1 | Active-high processor reset |
| reset_n_o | output | 1 | Active-low processor reset |
| wdog_stat_n_o | output | 1 | Latched watchdog status, low = timeout occurred or supply bad |

## Verification
The bench exercises the watchdog in several patterns, each aimed at one distinction:
- Left unserviced, it shows the long first period.
- Serviced once, it shows the short later periods.
- Serviced at a regular pace, it must never expire, which separates falling-edge restarts from level or rising-edge behaviour.
- Disabled, it must not expire even though the strobe is idle.

Pushbutton presses just below and well above the qualification length separate debounce from plain sampling. A supply drop in mid-count separates the combinational reset path from the counted release and shows that the long first period restarts. Internal-clock runs with each period select check that the select alone decides whether later periods shrink.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Timing set selected by the clock-source input
  typedef enum logic {
    CLK_EXT = 1'b0,
    CLK_INT = 1'b1
  } clk_src_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/supv_sync2.sv
// Two-flop synchronizer for a bundle of independent asynchronous levels
module supv_sync2 #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/supv_pbutton.sv
// Pushbutton qualifier: press must last PB_TICKS ticks before it counts
module supv_pbutton #(
  parameter int PB_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic low_i,      // synchronized, 1 = button held
  output logic pressed_o
);

  localparam int PW = $clog2(PB_TICKS + 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          prs_q, prs_d;

  always_comb begin
    cnt_d = cnt_q;
    prs_d = prs_q;
    if (!low_i) begin
      cnt_d = '0;
      prs_d = 1'b0;
    end else if (tick && !prs_q) begin
      if (cnt_q == PW'(PB_TICKS - 1)) begin
        prs_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prs_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      prs_q <= prs_d;
    end
  end

  assign pressed_o = prs_q;

endmodule

// File: rtl/supv_rst_hold.sv
// Reset stretcher: holds reset while any cause is present, then for lim_i ticks
module supv_rst_hold #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          supply_ok_i,
  input  logic          button_i,
  input  logic          trip_i,
  input  logic [CW-1:0] lim_i,
  output logic          hold_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;
  logic          cause;

  assign cause = !supply_ok_i || button_i || trip_i;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (cause) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q && tick) begin
      if (cnt_q >= lim_i - CW'(1)) begin
        hold_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  // chip reset behaves as a fresh power-up: reset held, count from zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/supv_watchdog.sv
// Strobe-serviced watchdog with long first period and latched status
module supv_watchdog #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run_i,        // reset inactive and supply good
  input  logic          enable_i,
  input  logic          fall_i,       // synchronized strobe falling edge
  input  logic          long_all_i,   // every period long
  input  logic [CW-1:0] long_lim_i,
  input  logic [CW-1:0] short_lim_i,
  output logic          trip_o,
  output logic          stat_o        // 1 = timeout latched
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, first_d;
  logic          stat_q, stat_d;
  logic [CW-1:0] lim;
  logic          at_end;
  logic          trip;

  assign lim    = (first_q || long_all_i) ? long_lim_i : short_lim_i;
  assign at_end = (cnt_q >= lim - CW'(1));
  assign trip   = run_i && enable_i && !fall_i && tick && at_end;

  always_comb begin
    // first-period flag: re-armed by any reset, dropped by service
    first_d = first_q;
    if (!run_i)      first_d = 1'b1;
    else if (fall_i) first_d = 1'b0;

    cnt_d = cnt_q;
    if (!run_i || !enable_i || fall_i) cnt_d = '0;
    else if (tick)                      cnt_d = at_end ? '0 : cnt_q + CW'(1);

    stat_d = stat_q;
    if (!enable_i)   stat_d = 1'b0;
    else if (fall_i) stat_d = 1'b0;
    else if (trip)   stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      stat_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      stat_q  <= stat_d;
    end
  end

  assign trip_o = trip;
  assign stat_o = stat_q;

endmodule

// File: rtl/supv_reset_wdog.sv
module supv_reset_wdog
  import supv_pkg::*;
#(
  parameter int RST_EXT_TICKS  = 641,
  parameter int WD_EXT_SHORT   = 5120,
  parameter int WD_LONG_FACTOR = 4,
  parameter int RST_INT_TICKS  = 85,
  parameter int WD_INT_SHORT   = 170,
  parameter int WD_INT_LONG    = 2700,
  parameter int PB_TICKS       = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic button_n,
  input  logic strobe,
  input  logic wd_enable,
  input  logic clk_int,
  input  logic long_sel,
  output logic reset_o,
  output logic reset_n_o,
  output logic wdog_stat_n_o
);

  localparam int WD_EXT_LONG = WD_EXT_SHORT * WD_LONG_FACTOR;
  localparam int MAX_T = max_of(max_of(max_of(RST_EXT_TICKS, RST_INT_TICKS),
                                       max_of(WD_EXT_LONG, WD_INT_LONG)),
                                max_of(WD_EXT_SHORT, WD_INT_SHORT));
  localparam int CW = $clog2(MAX_T + 1);

  clk_src_e      src;
  logic [1:0]    sync_q;
  logic          btn_s, strb_s;
  logic          strb_prev_q;
  logic          strobe_fall;
  logic          pb_pressed;
  logic          hold;
  logic          wd_trip;
  logic          wd_stat;
  logic          long_all;
  logic [CW-1:0] lim_rst, lim_long, lim_short;

  assign src = clk_src_e'(clk_int);

  always_comb begin
    case (src)
      CLK_INT: begin
        lim_rst   = CW'(RST_INT_TICKS);
        lim_long  = CW'(WD_INT_LONG);
        lim_short = CW'(WD_INT_SHORT);
      end
      default: begin
        lim_rst   = CW'(RST_EXT_TICKS);
        lim_long  = CW'(WD_EXT_LONG);
        lim_short = CW'(WD_EXT_SHORT);
      end
    endcase
  end

  assign long_all = (src == CLK_INT) && long_sel;

  // idle levels: button released, strobe high
  supv_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({button_n, strobe}),
    .q_o   (sync_q)
  );

  assign btn_s  = sync_q[1];
  assign strb_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev_q <= 1'b1;
    else        strb_prev_q <= strb_s;
  end

  assign strobe_fall = strb_prev_q && !strb_s;

  supv_pbutton #(.PB_TICKS(PB_TICKS)) u_pb (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .low_i     (!btn_s),
    .pressed_o (pb_pressed)
  );

  supv_rst_hold #(.CW(CW)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .supply_ok_i (supply_ok),
    .button_i    (pb_pressed),
    .trip_i      (wd_trip),
    .lim_i       (lim_rst),
    .hold_o      (hold)
  );

  // supply failure forces reset without waiting for a clock edge
  assign reset_o   = hold || !supply_ok;
  assign reset_n_o = !reset_o;

  supv_watchdog #(.CW(CW)) u_wd (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run_i       (!reset_o),
    .enable_i    (wd_enable),
    .fall_i      (strobe_fall),
    .long_all_i  (long_all),
    .long_lim_i  (lim_long),
    .short_lim_i (lim_short),
    .trip_o      (wd_trip),
    .stat_o      (wd_stat)
  );

  assign wdog_stat_n_o = supply_ok && !wd_stat;

endmodule

// File: rtl/supv_reset_wdog_chk.sv
module supv_reset_wdog_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_ok,
  input logic wd_enable,
  input logic reset_o,
  input logic reset_n_o,
  input logic wdog_stat_n_o,
  input logic strobe_fall,
  input logic wd_trip
);

  // R2
  supply_low_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (reset_o && !reset_n_o && !wdog_stat_n_o));

  // R3
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_o) |-> (supply_ok && $past(tick)));

  // R8
  trip_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trip |=> (reset_o && !wdog_stat_n_o));

  // R9
  disabled_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |-> !wd_trip);

  // R5
  no_trip_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |-> !wd_trip);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && $past(supply_ok) && $rose(wdog_stat_n_o))
      |-> ($past(strobe_fall) || !$past(wd_enable)));

endmodule

bind supv_reset_wdog supv_reset_wdog_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .supply_ok     (supply_ok),
  .wd_enable     (wd_enable),
  .reset_o       (reset_o),
  .reset_n_o     (reset_n_o),
  .wdog_stat_n_o (wdog_stat_n_o),
  .strobe_fall   (strobe_fall),
  .wd_trip       (wd_trip)
);

// File: tb/supv_reset_wdog_tb.sv
`timescale 1ns/1ps
module supv_reset_wdog_tb_top;

  localparam int P_RST_EXT = 5;
  localparam int P_EXT_SH  = 6;
  localparam int P_FACT    = 4;
  localparam int P_RST_INT = 3;
  localparam int P_INT_SH  = 5;
  localparam int P_INT_LG  = 12;
  localparam int P_PB      = 4;

  logic clk, rst_n, tick, supply_ok, button_n, strobe, wd_enable, clk_int, long_sel;
  logic reset_o, reset_n_o, wdog_stat_n_o;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit done = 0;

  supv_reset_wdog #(
    .RST_EXT_TICKS(P_RST_EXT), .WD_EXT_SHORT(P_EXT_SH), .WD_LONG_FACTOR(P_FACT),
    .RST_INT_TICKS(P_RST_INT), .WD_INT_SHORT(P_INT_SH), .WD_INT_LONG(P_INT_LG),
    .PB_TICKS(P_PB)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .button_n(button_n), .strobe(strobe), .wd_enable(wd_enable),
    .clk_int(clk_int), .long_sel(long_sel), .reset_o(reset_o),
    .reset_n_o(reset_n_o), .wdog_stat_n_o(wdog_stat_n_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // tick: one cycle in three
  initial begin
    int tc = 0;
    tick = 0;
    forever begin
      @(posedge clk); #1;
      tc++;
      tick = (tc % 3 == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_btn_q[$];           // synchronizer pipelines as queues
  bit m_stb_q[$];
  bit m_stb_last;
  int m_pb_ticks; bit m_pb;
  bit m_hold; int m_rel_ticks;
  int m_wd_ticks; bit m_first; bit m_stat;

  task automatic model_clear();
    m_btn_q = '{1, 1};
    m_stb_q = '{1, 1};
    m_stb_last = 1;
    m_pb_ticks = 0; m_pb = 0;
    m_hold = 1; m_rel_ticks = 0;
    m_wd_ticks = 0; m_first = 1; m_stat = 0;
  endtask

  always @(posedge clk) begin : model
    bit btn_now, stb_now, fell, in_rst, expire, nb, nh, nf, ns;
    int period, rlen, npt, nrt, nwt;
    if (!rst_n) begin
      model_clear();
    end else begin
      btn_now = m_btn_q[0];
      stb_now = m_stb_q[0];
      fell    = m_stb_last && !stb_now;
      in_rst  = m_hold || !supply_ok;
      rlen    = clk_int ? P_RST_INT : P_RST_EXT;
      if (m_first || (clk_int && long_sel)) period = clk_int ? P_INT_LG : P_EXT_SH * P_FACT;
      else                                  period = clk_int ? P_INT_SH : P_EXT_SH;
      expire = !in_rst && wd_enable && !fell && tick && (m_wd_ticks + 1 >= period);
      // pushbutton
      nb = m_pb; npt = m_pb_ticks;
      if (btn_now) begin nb = 0; npt = 0; end
      else if (tick && !m_pb) begin
        if (m_pb_ticks + 1 == P_PB) begin nb = 1; npt = 0; end
        else npt = m_pb_ticks + 1;
      end
      // reset stretch
      nh = m_hold; nrt = m_rel_ticks;
      if (!supply_ok || m_pb || expire) begin nh = 1; nrt = 0; end
      else if (m_hold && tick) begin
        if (m_rel_ticks + 1 >= rlen) begin nh = 0; nrt = 0; end
        else nrt = m_rel_ticks + 1;
      end
      // watchdog
      nf = in_rst ? 1'b1 : (fell ? 1'b0 : m_first);
      if (in_rst || !wd_enable || fell) nwt = 0;
      else if (tick) nwt = expire ? 0 : m_wd_ticks + 1;
      else nwt = m_wd_ticks;
      ns = m_stat;
      if (!wd_enable || fell) ns = 0;
      else if (expire) ns = 1;
      m_pb = nb; m_pb_ticks = npt; m_hold = nh; m_rel_ticks = nrt;
      m_first = nf; m_wd_ticks = nwt; m_stat = ns;
      m_stb_last = stb_now;
      void'(m_btn_q.pop_front()); m_btn_q.push_back(button_n);
      void'(m_stb_q.pop_front()); m_stb_q.push_back(strobe);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " reset_o vs model"}, reset_o, m_hold || !supply_ok);
      chk({cur_req, " reset_n_o vs model"}, reset_n_o, !(m_hold || !supply_ok));
      chk({cur_req, " wdog_stat_n_o vs model"}, wdog_stat_n_o, supply_ok && !m_stat);
    end
  end

  // ---------------- stimulus helpers ----------------
  // both count tasks start evaluating at the current negedge
  task automatic count_release(output int n);
    n = 0;
    while (reset_o) begin
      if (tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic count_to_trip(output int n, output int first_stat);
    n = 0;
    first_stat = wdog_stat_n_o;
    while (wdog_stat_n_o) begin
      if (!reset_o && tick) n++;
      @(negedge clk);
    end
  endtask

  // raise strobe, then lower it; ends at the negedge after the fall is taken
  task automatic do_fall();
    @(posedge clk); #1 strobe = 1;
    repeat (3) @(posedge clk);
    #1 strobe = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chip_reset(input bit mode, input bit lsel);
    @(posedge clk); #1;
    rst_n = 0; clk_int = mode; long_sel = lsel; strobe = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int n, fs;
    rst_n = 0; supply_ok = 1; button_n = 1; strobe = 1; wd_enable = 1;
    clk_int = 0; long_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset_o in reset", reset_o, 1);
    chk("R1 reset_n_o in reset", reset_n_o, 0);
    chk("R1 status in reset", wdog_stat_n_o, 1);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);

    cur_req = "R3";
    count_release(n);
    chk("R3 ext release ticks", n, P_RST_EXT);

    cur_req = "R6";
    count_to_trip(n, fs);
    chk("R6 ext first period", n, P_EXT_SH * P_FACT);
    chk("R8 reset after timeout", reset_o, 1);

    cur_req = "R8";
    count_release(n);
    chk("R3 release after timeout", n, P_RST_EXT);
    chk("R8 status held after release", wdog_stat_n_o, 0);

    cur_req = "R7";
    do_fall();
    count_to_trip(n, fs);
    chk("R7 status cleared by fall", fs, 1);
    chk("R6 ext later period", n, P_EXT_SH);

    count_release(n);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 strobe = 1;
      repeat (3) @(posedge clk);
      #1 strobe = 0;
      repeat (6) @(posedge clk);
    end
    @(negedge clk);
    chk("R7 serviced no reset", reset_o, 0);
    chk("R7 serviced status clear", wdog_stat_n_o, 1);

    cur_req = "R9";
    @(posedge clk); #1 wd_enable = 0; strobe = 1;
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk("R9 disabled no reset", reset_o, 0);
    chk("R9 disabled status", wdog_stat_n_o, 1);

    cur_req = "R4";
    @(posedge clk); #1 button_n = 0;
    repeat (6) @(posedge clk);
    #1 button_n = 1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R4 short press ignored", reset_o, 0);
    @(posedge clk); #1 button_n = 0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R4 long press resets", reset_o, 1);
    @(posedge clk); #1 button_n = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R4 released after press", reset_o, 0);

    cur_req = "R2";
    @(posedge clk); #1 wd_enable = 1;
    do_fall();
    repeat (4) @(posedge clk);
    #1 supply_ok = 0;
    @(negedge clk);
    chk("R2 supply low reset", reset_o, 1);
    chk("R2 supply low status", wdog_stat_n_o, 0);
    repeat (20) @(posedge clk);
    #1 supply_ok = 1;
    @(negedge clk);
    cur_req = "R11";
    count_release(n);
    chk("R3 release after supply", n, P_RST_EXT);
    count_to_trip(n, fs);
    chk("R11 long period after supply", n, P_EXT_SH * P_FACT);

    cur_req = "R10";
    chip_reset(1, 1);
    count_release(n);
    chk("R3 int release ticks", n, P_RST_INT);
    count_to_trip(n, fs);
    chk("R10 int first long", n, P_INT_LG);
    count_release(n);
    do_fall();
    count_to_trip(n, fs);
    chk("R10 int always long", n, P_INT_LG);

    chip_reset(1, 0);
    count_release(n);
    count_to_trip(n, fs);
    chk("R10 int first long sel0", n, P_INT_LG);
    count_release(n);
    do_fall();
    count_to_trip(n, fs);
    chk("R10 int later short", n, P_INT_SH);

    repeat (5) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog %s: actual hung expected finish", cur_req);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule